// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Pipeline Sequencer

This block sequences a two-stage processor pipeline. Every instruction cycle lasts four clock ticks, called phases Q1 to Q4. While one instruction executes, the next one is fetched from the address the block presents. The block does four things:

- It drives a one-hot phase strobe.
- It advances a byte-addressed program counter at the start of each cycle.
- It moves the fetched word into the instruction register at the start of the next cycle.
- During cycles whose instruction is valid, it pulses an operand-read strobe in Q2 and a destination-write strobe in Q4.

The execute logic outside the block reports a taken branch, together with its target, during Q4. The block then loads the target into the program counter. The word it had already prefetched is discarded and turned into a no-op cycle. A taken branch therefore costs two instruction cycles. Decode, the ALU and program memory live outside this block.

Top module: `qp_pipe_seq`

## Requirements
- R1: While reset is high, and in the first tick after it is released, the outputs take these values: phase_q = 4'b0001 (Q1), fetch_addr = RESET_ADDR with its low bit cleared, ir = NOP_WORD, and ex_valid, pc_adv, rd_stb and wr_stb all low.
- R2: phase_q is one-hot. It rotates bit 0 (Q1), bit 1 (Q2), bit 2 (Q3), bit 3 (Q4) and then back to bit 0, one step per clock.
- R3: fetch_addr changes only at entry to Q1, and pc_adv is high for the Q1 tick of every cycle after the first. When no branch is taken, fetch_addr grows by 2, and its bit 0 is always 0.
- R4: At entry to Q1, ir loads the insn_word value that was present during the preceding Q4, unless that cycle is flushed. In all other phases ir holds its value.
- R5: The first cycle after reset only fetches: ex_valid stays low. From then on, ex_valid is high in every cycle that is not flushed.
- R6: rd_stb is high exactly in Q2, and wr_stb exactly in Q4, of cycles where ex_valid is high. Neither is ever high at any other time.
- R7: If br_taken is high during Q4 of a cycle with ex_valid high, fetch_addr equals br_target with bit 0 cleared from the following Q1.
- R8: The cycle after a taken branch is a flush cycle: ex_valid is low, ir equals NOP_WORD and neither strobe fires. The instruction fetched from the branch target executes in the cycle after the flush cycle.
- R9: br_taken has no effect when it is high in Q1 to Q3, or in Q4 of a cycle with ex_valid low. In that case fetch_addr advances by 2 as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_word | input | INSN_W | Word read from fetch_addr, sampled in Q4 |
| br_taken | input | 1 | Branch taken by the executing instruction, sampled in Q4 |
| br_target | input | ADDR_W | Byte address of the branch target |
| phase_q | output | 4 | One-hot phase strobe, bit 0 = Q1 |
| pc_adv | output | 1 | High in the Q1 tick in which the program counter took a new value |
| fetch_addr | output | ADDR_W | Address of the word being fetched |
| ir | output | INSN_W | Instruction register of the execute stage |
| ex_valid | output | 1 | The instruction in ir is a real instruction, not a flush |
| rd_stb | output | 1 | Operand-read strobe, Q2 |
| wr_stb | output | 1 | Destination-write strobe, Q4 |

## Verification
The assertions assume four things:

- Reset is high from time zero for at least one edge.
- PC_STEP is a power of two.
- insn_word is the word at fetch_addr by Q4.
- br_target is meaningful whenever br_taken is high in Q4.

The bench meets these conditions as follows. It holds reset from the start of each run. It derives insn_word combinationally from fetch_addr through an address-dependent function, so every word is distinct and a word read in the wrong cycle shows up. Branch flags change only between edges. They are deliberately raised in the wrong phases and during flush cycles, and some targets are odd, so that the bench exercises the input combinations the design must ignore or correct.

// File: rtl/qp_pkg.sv
package qp_pkg;
  localparam int unsigned NUM_PH   = 4;
  localparam int unsigned PH_FETCH = 0;  // Q1: PC and IR update
  localparam int unsigned PH_RD    = 1;  // Q2: operand read
  localparam int unsigned PH_WR    = 3;  // Q4: destination write
  localparam int unsigned PH_LAST  = NUM_PH - 1;
  typedef logic [NUM_PH-1:0] ph_vec_t;
endpackage

// File: rtl/qp_phase_gen.sv
module qp_phase_gen
  import qp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output ph_vec_t ph,
  output logic    cyc_end
);
  always_ff @(posedge clk) begin
    if (rst) ph <= ph_vec_t'(1);
    else     ph <= {ph[NUM_PH-2:0], ph[NUM_PH-1]};
  end

  assign cyc_end = ph[PH_LAST];

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(ph) == 1);
endmodule

// File: rtl/qp_fetch.sv
module qp_fetch #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PC_STEP = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_end,
  input  logic              take,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc,
  output logic              pc_adv
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(STEP - ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_ADDR & ALIGN_MASK;
      pc_adv <= 1'b0;
    end else begin
      pc_adv <= cyc_end;
      if (cyc_end) pc <= take ? (target & ALIGN_MASK) : (pc + STEP);
    end
  end

  // R3
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    (pc & ~ALIGN_MASK) == '0);
  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pc_adv |-> $stable(pc));
endmodule

// File: rtl/qp_exec.sv
module qp_exec
  import qp_pkg::*;
#(
  parameter int unsigned INSN_W = 16,
  parameter logic [INSN_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  ph_vec_t           ph,
  input  logic [INSN_W-1:0] insn_in,
  input  logic              br_taken,
  output logic              take,
  output logic [INSN_W-1:0] ir,
  output logic              ex_valid,
  output logic              rd_stb,
  output logic              wr_stb
);
  // branch only counts when sampled in Q4 of a real instruction
  assign take = ph[PH_LAST] & ex_valid & br_taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir       <= NOP_WORD;
      ex_valid <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
    end else begin
      rd_stb <= ph[PH_RD-1] & ex_valid;
      wr_stb <= ph[PH_WR-1] & ex_valid;
      if (ph[PH_LAST]) begin
        ir       <= take ? NOP_WORD : insn_in;
        ex_valid <= !take;
      end
    end
  end

  // R4
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ph[PH_FETCH] |-> $stable(ir));
  // R8
  flush_nop_chk: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |-> ir == NOP_WORD);
  // R6
  strobe_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |-> ex_valid);
  // R6
  rd_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> ph[PH_RD]);
  // R5
  valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ex_valid) |-> ph[PH_FETCH]);
endmodule

// File: rtl/qp_pipe_seq.sv
module qp_pipe_seq
  import qp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned INSN_W = 16,
  parameter int unsigned PC_STEP = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter logic [INSN_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] insn_word,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  output logic [3:0]        phase_q,
  output logic              pc_adv,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [INSN_W-1:0] ir,
  output logic              ex_valid,
  output logic              rd_stb,
  output logic              wr_stb
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(PC_STEP) - ADDR_W'(1));

  ph_vec_t ph;
  logic    cyc_end;
  logic    take;

  qp_phase_gen u_phase (
    .clk     (clk),
    .rst     (rst),
    .ph      (ph),
    .cyc_end (cyc_end)
  );

  qp_fetch #(
    .ADDR_W     (ADDR_W),
    .PC_STEP    (PC_STEP),
    .RESET_ADDR (RESET_ADDR)
  ) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .cyc_end (cyc_end),
    .take    (take),
    .target  (br_target),
    .pc      (fetch_addr),
    .pc_adv  (pc_adv)
  );

  qp_exec #(
    .INSN_W   (INSN_W),
    .NOP_WORD (NOP_WORD)
  ) u_exec (
    .clk      (clk),
    .rst      (rst),
    .ph       (ph),
    .insn_in  (insn_word),
    .br_taken (br_taken),
    .take     (take),
    .ir       (ir),
    .ex_valid (ex_valid),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb)
  );

  assign phase_q = ph;

  // R6
  wr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> ph[PH_WR]);
  // R3
  adv_phase_chk: assert property (@(posedge clk) disable iff (rst)
    pc_adv |-> ph[PH_FETCH]);
  // R7
  branch_target_chk: assert property (@(posedge clk) disable iff (rst)
    $past(take) |-> fetch_addr == ($past(br_target) & ALIGN_MASK));
  // R8
  flush_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !ex_valid);
endmodule

// File: tb/qp_pipe_seq_tb_top.sv
module qp_pipe_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_taken = 1'b0;
  logic [15:0] br_target = '0;
  logic [15:0] insn_word;
  logic [3:0]  phase_q;
  logic        pc_adv, ex_valid, rd_stb, wr_stb;
  logic [15:0] fetch_addr, ir;

  always #4 clk = ~clk;  // 125 MHz

  qp_pipe_seq dut_i (
    .clk(clk), .rst(rst), .insn_word(insn_word), .br_taken(br_taken),
    .br_target(br_target), .phase_q(phase_q), .pc_adv(pc_adv),
    .fetch_addr(fetch_addr), .ir(ir), .ex_valid(ex_valid),
    .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  function automatic logic [15:0] word_at(input logic [15:0] a);
    return (a * 16'd40503) ^ 16'h5A5A;
  endfunction

  assign insn_word = word_at(fetch_addr);

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  // reference state, one step per clock
  int          mph, cyc;
  logic [15:0] mpc, mir;
  logic        mval, madv, mrd, mwr, tk_flag, ign_flag, anybr;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input bit at_reset);
    string tpc, tval, tir;
    tpc  = at_reset ? "R1" : (tk_flag ? "R7" : (ign_flag ? "R9" : "R3"));
    tval = at_reset ? "R1" : (tk_flag ? "R8" : "R5");
    tir  = at_reset ? "R1" : (tk_flag ? "R8" : "R4");
    chk(at_reset ? "R1" : "R2", "phase_q", 32'(phase_q), 32'(4'b0001 << mph));
    chk(at_reset ? "R1" : "R3", "pc_adv", 32'(pc_adv), 32'(madv));
    chk(tpc, "fetch_addr", 32'(fetch_addr), 32'(mpc));
    chk(tir, "ir", 32'(ir), 32'(mir));
    chk(tval, "ex_valid", 32'(ex_valid), 32'(mval));
    chk(at_reset ? "R1" : "R6", "rd_stb", 32'(rd_stb), 32'(mrd));
    chk(at_reset ? "R1" : "R6", "wr_stb", 32'(wr_stb), 32'(mwr));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    br_taken = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mph = 0; cyc = 0; mpc = 16'h0000; mir = 16'h0000;
    mval = 0; madv = 0; mrd = 0; mwr = 0;
    tk_flag = 0; ign_flag = 0; anybr = 0;
    compare(1'b1);  // R1 reset state
  endtask

  // drive inputs for the coming edge and advance the reference model
  task automatic step(input int pat);
    logic tk, nrd, nwr;
    if (mph == 3)
      br_taken = (pat == 3) ? 1'b1 : (((cyc * (pat + 2)) % 5) < 2);
    else
      br_taken = ((cyc + mph + pat) % 2) == 1;  // R9 noise in Q1..Q3
    br_target = 16'(cyc * 37 + pat * 101 + 3);
    tk  = (mph == 3) && br_taken && mval;
    nrd = (mph == 0) && mval;
    nwr = (mph == 2) && mval;
    anybr = anybr | br_taken;
    if (mph == 3) begin
      madv     = 1'b1;
      mir      = tk ? 16'h0000 : word_at(mpc);
      mpc      = tk ? (br_target & 16'hFFFE) : (mpc + 16'd2);
      mval     = !tk;
      tk_flag  = tk;
      ign_flag = !tk && anybr;
      anybr    = 1'b0;
      cyc++;
    end else begin
      madv = 1'b0;
    end
    mrd = nrd;
    mwr = nwr;
    mph = (mph + 1) % 4;
  endtask

  initial begin
    for (int pat = 0; pat < 4; pat++) begin
      do_reset();
      step(pat);
      for (int n = 0; n < 240; n++) begin
        @(negedge clk);
        compare(1'b0);
        step(pat);
      end
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule